// File: doc/BRIEF.md
# SPI Master Byte Engine

This block is the master side of a serial peripheral link. It moves one byte in each direction per transfer. A host sets up the link through a control byte: an operating mode, the clock polarity, the clock phase and one of four bit rates. The host then offers a byte on a valid/ready port. The engine sends that byte most significant bit first on `mosi`. It generates exactly eight pulses on `sck` and shifts the peer's reply in from `miso`. When the eighth bit completes, the received byte appears on `rx_data`, a sticky completion flag sets, and `irq` pulses for one cycle.

Only the host clears the completion flag, by writing the control byte with bit 7 at 0. Slave select is driven by the host outside this block. The bit rate comes from dividing the system clock. With a 6 MHz system clock the four rate codes give 2, 1, 0.5 and 0.0625 Mbit/s. At the fastest code the clock is active for one system cycle and idle for two. At all other codes it runs at half duty.

The transmit port follows these back-pressure rules. `tx_ready` is high only while the mode field selects master and no transfer is running. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. A byte offered while `tx_ready` is low is dropped, not held, and leaves the running transfer untouched.

Top module: `spi_byte_master`

## Requirements
- R1: After reset every control bit reads 0, and `sck`, `mosi`, `irq`, `tx_ready` and `rx_data` are all 0.
- R2: Control bits [5:4] select the mode: 00 off, 01 master, 10 slave (not served here), 11 reserved. Only 01 raises `tx_ready` and lets a transfer run. Under any other code no byte is accepted and `sck` stays at its idle level.
- R3: Each accepted byte produces exactly 8 active `sck` pulses. The byte leaves on `mosi` MSB first. The 8 bits sampled from `miso` are shown MSB first on `rx_data` once the transfer completes.
- R4: Control bits [1:0] set the bit period: codes 00, 01, 10 and 11 give 3, 6, 12 and 96 system clocks. `irq` is high in the cycle that follows exactly 8×period clock edges after the accepting edge.
- R5: At code 00 every `sck` pulse is active for 1 clock, with 2 idle clocks per bit. At the other codes the active part lasts half the bit period.
- R6: Control bit 3 sets the idle level of `sck`: 1 idles high, 0 idles low.
- R7: Control bit 2 sets the phase. At 0, `mosi` is valid before the first edge of each bit and `miso` is sampled on that first edge. At 1, `mosi` changes on the first edge and `miso` is sampled on the second.
- R8: Control bit 7 is the completion flag. It sets in the same cycle as the one-cycle `irq` pulse. It stays set until the host writes the control byte with bit 7 at 0. Writing 1 to bit 7 has no effect.
- R9: Control bit 6 reads 1 while a transfer runs, and `tx_ready` is then low. A byte offered in that time is discarded and does not alter the bits being shifted or the received result.
- R10: Leaving master mode during a transfer aborts it. `sck` returns to idle at once, no `irq` or completion flag follows, and `rx_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte to write |
| ctl_rdata | output | 8 | Control and status byte: flag, busy, mode, polarity, phase, rate |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Engine can take a byte |
| rx_data | output | 8 | Last completed received byte |
| irq | output | 1 | One-cycle completion pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest situation to reach from the ports is an offer of a new byte in the middle of a shift, and an abort by a mode change in the middle of a shift. Both happen deep inside a long transfer, and their only evidence is an absence: no corrupted result and no `irq`. The bench counts clock edges from the accepting edge and injects the competing byte at a fixed point inside the transfer. For the abort case it rewrites the mode after 100 cycles at the slowest rate. It then waits longer than a full transfer while counting `irq` pulses. A reactive slave model captures `mosi` and drives `miso` on `sck` edges. It runs across all 16 combinations of rate, polarity and phase, so that the received bytes on both sides can be compared with what was sent.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_MASTER = 2'b01,
    MODE_SLAVE  = 2'b10,
    MODE_RSVD   = 2'b11
  } comm_mode_e;

  // Writable configuration, laid out as control bits [5:0]
  typedef struct packed {
    comm_mode_e  mode;
    logic        cpol;
    logic        cpha;
    logic [1:0]  rate;
  } link_cfg_t;

  // Length of one half of a bit window in system clocks.
  // Even dividers split evenly; odd dividers give the active half a third.
  function automatic int unsigned half_len(input int unsigned div, input bit act);
    if (div % 2 == 0) return div / 2;
    else if (act)     return div / 3;
    else              return div - div / 3;
  endfunction

endpackage

// File: rtl/spi_rate_timer.sv
module spi_rate_timer #(
  parameter int unsigned DIV0 = 3,
  parameter int unsigned DIV1 = 6,
  parameter int unsigned DIV2 = 12,
  parameter int unsigned DIV3 = 96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       active,
  input  logic [1:0] rate,
  output logic       phase_end
);
  import spi_eng_pkg::*;

  localparam int unsigned MAXA = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int unsigned MAXB = (DIV2 > DIV3) ? DIV2 : DIV3;
  localparam int unsigned MAXD = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int unsigned CW   = $clog2(MAXD + 1);

  function automatic int unsigned div_of(input int g);
    case (g)
      0:       return DIV0;
      1:       return DIV1;
      2:       return DIV2;
      default: return DIV3;
    endcase
  endfunction

  logic [CW-1:0] len_act  [4];
  logic [CW-1:0] len_idle [4];

  for (genvar g = 0; g < 4; g++) begin : g_len
    assign len_act[g]  = CW'(half_len(div_of(g), 1'b1));
    assign len_idle[g] = CW'(half_len(div_of(g), 1'b0));
  end

  logic [CW-1:0] cnt;
  logic [CW-1:0] cur_len;

  assign cur_len   = active ? len_act[rate] : len_idle[rate];
  assign phase_end = run && (cnt == cur_len - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || phase_end) cnt <= '0;
    else                       cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start,
  input  logic [W-1:0] tx_byte,
  input  logic         cpha,
  input  logic         phase_end,
  input  logic         miso,
  output logic         busy,
  output logic         active,
  output logic         mosi,
  output logic         fin,
  output logic         done_pulse,
  output logic [W-1:0] rx_byte
);
  localparam int unsigned BCW = (W > 1) ? $clog2(W) : 1;

  logic           phase;   // 0: first half of bit window, 1: second half
  logic [BCW-1:0] bit_cnt;
  logic [W-1:0]   shreg;
  logic           samp;

  // Phase 0 window starts idle, phase 1 window starts active
  assign active = busy && (phase != cpha);
  assign mosi   = busy ? shreg[W-1] : 1'b0;
  assign fin    = busy && en && phase_end && phase && (bit_cnt == BCW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      phase      <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      samp       <= 1'b0;
      rx_byte    <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (!en) begin
        busy  <= 1'b0;
        phase <= 1'b0;
      end else if (start && !busy) begin
        busy    <= 1'b1;
        phase   <= 1'b0;
        bit_cnt <= '0;
        shreg   <= tx_byte;
      end else if (busy && phase_end) begin
        if (!phase) begin
          samp  <= miso;
          phase <= 1'b1;
        end else begin
          phase <= 1'b0;
          shreg <= {shreg[W-2:0], samp};
          if (fin) begin
            busy       <= 1'b0;
            done_pulse <= 1'b1;
            rx_byte    <= {shreg[W-2:0], samp};
          end else begin
            bit_cnt <= bit_cnt + BCW'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic                   wr_flag,
  input  logic [5:0]             wr_cfg,
  input  logic                   set_done,
  output spi_eng_pkg::link_cfg_t cfg,
  output logic                   done
);
  import spi_eng_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      done <= 1'b0;
    end else begin
      if (wr) cfg <= link_cfg_t'(wr_cfg);
      // hardware set wins over a host clear in the same cycle
      if (set_done)            done <= 1'b1;
      else if (wr && !wr_flag) done <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int unsigned W    = 8,
  parameter int unsigned DIV0 = 3,
  parameter int unsigned DIV1 = 6,
  parameter int unsigned DIV2 = 12,
  parameter int unsigned DIV3 = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_wr,
  input  logic [7:0]   ctl_wdata,
  output logic [7:0]   ctl_rdata,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_ready,
  output logic [W-1:0] rx_data,
  output logic         irq,
  output logic         sck,
  output logic         mosi,
  input  logic         miso
);
  import spi_eng_pkg::*;

  link_cfg_t cfg;
  logic      done, busy, active, en, start, phase_end, fin;
  logic      unused_wbit;

  assign unused_wbit = ctl_wdata[6];

  assign en       = (cfg.mode == MODE_MASTER);
  assign tx_ready = en && !busy;
  assign start    = tx_valid && tx_ready;
  assign sck      = cfg.cpol ^ (en && active);
  assign ctl_rdata = {done, busy, cfg};

  spi_ctrl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctl_wr),
    .wr_flag  (ctl_wdata[7]),
    .wr_cfg   (ctl_wdata[5:0]),
    .set_done (fin),
    .cfg      (cfg),
    .done     (done)
  );

  spi_rate_timer #(
    .DIV0 (DIV0), .DIV1 (DIV1), .DIV2 (DIV2), .DIV3 (DIV3)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy && en),
    .active    (active),
    .rate      (cfg.rate),
    .phase_end (phase_end)
  );

  spi_shift_core #(.W(W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .start      (start),
    .tx_byte    (tx_data),
    .cpha       (cfg.cpha),
    .phase_end  (phase_end),
    .miso       (miso),
    .busy       (busy),
    .active     (active),
    .mosi       (mosi),
    .fin        (fin),
    .done_pulse (irq),
    .rx_byte    (rx_data)
  );

endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic       wr_flag,
  input logic [7:0] ctl_rdata,
  input logic       tx_ready,
  input logic       irq,
  input logic       sck
);

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctl_rdata[7]);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[7] && !(ctl_wr && !wr_flag)) |=> ctl_rdata[7]);

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[6] |-> !tx_ready);

  assert_idle_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[5:4] != 2'b01) |-> (sck == ctl_rdata[3]));

  assert_fast_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[5:4] == 2'b01 && ctl_rdata[1:0] == 2'b00 && ctl_rdata[6]
     && sck != ctl_rdata[3] && !ctl_wr) |=> (sck == $past(ctl_rdata[3])));

endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_wr    (ctl_wr),
  .wr_flag   (ctl_wdata[7]),
  .ctl_rdata (ctl_rdata),
  .tx_ready  (tx_ready),
  .irq       (irq),
  .sck       (sck)
);

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       irq, sck, mosi;
  logic       miso;

  spi_byte_master dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_data(rx_data), .irq(irq), .sck(sck),
    .mosi(mosi), .miso(miso)
  );

  always #4 clk = ~clk;

  int  nchk = 0, nerr = 0;
  bit  b_cpol = 0, b_cpha = 0, mon = 0;
  logic [7:0] slv_seed = '0;

  // Slave model: reacts to sck edges while mon is high
  logic [7:0] s_tx, s_rx;
  logic       sck_prev;
  always @(sck or mon or slv_seed) begin
    if (!mon) begin
      s_tx = slv_seed; s_rx = '0; sck_prev = sck;
      miso = b_cpha ? 1'b0 : slv_seed[7];
    end else if (sck != sck_prev) begin
      sck_prev = sck;
      if (sck != b_cpol) begin
        if (!b_cpha) s_rx = {s_rx[6:0], mosi};
        else begin miso = s_tx[7]; s_tx = s_tx << 1; end
      end else begin
        if (!b_cpha) begin s_tx = s_tx << 1; miso = s_tx[7]; end
        else s_rx = {s_rx[6:0], mosi};
      end
    end
  end

  // Pulse monitor sampled at the falling edge
  int pulses, act_run, amin, amax;
  always @(negedge clk) begin
    if (!mon) begin
      pulses = 0; act_run = 0; amin = 1000; amax = 0;
    end else if (sck != b_cpol) act_run++;
    else if (act_run > 0) begin
      pulses++;
      if (act_run < amin) amin = act_run;
      if (act_run > amax) amax = act_run;
      act_run = 0;
    end
  end

  int irq_cnt = 0;
  always @(negedge clk) if (irq) irq_cnt++;

  function automatic int per(input int r);
    return (r == 0) ? 3 : (r == 1) ? 6 : (r == 2) ? 12 : 96;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic run_xfer(input logic [7:0] tx, input logic [7:0] sv,
                          input int r, input bit inject);
    int n, ea;
    @(negedge clk); slv_seed = sv;
    @(negedge clk); mon = 1'b1; tx_valid = 1'b1; tx_data = tx;
    check(tx_ready == 1'b1, "R2 ready in master idle", tx_ready, 1);
    @(negedge clk); tx_valid = 1'b0;
    check(ctl_rdata[6] == 1'b1, "R9 busy flag", ctl_rdata[6], 1);
    if (!b_cpha)
      check(sck == b_cpol && mosi == tx[7], "R7 data before first edge", mosi, tx[7]);
    else
      check(sck != b_cpol, "R7 first edge at start", sck, !b_cpol);
    n = 0;
    while (!irq && n < 2000) begin
      @(negedge clk); n++;
      if (inject && n == 20) begin
        check(tx_ready == 1'b0, "R9 ready low while busy", tx_ready, 0);
        tx_valid = 1'b1; tx_data = ~tx;
      end else if (inject && n == 21) tx_valid = 1'b0;
    end
    check(n == 8 * per(r), "R4 transfer length", n, 8 * per(r));
    check(ctl_rdata[7] == 1'b1, "R8 flag with irq", ctl_rdata[7], 1);
    @(negedge clk);
    check(irq == 1'b0, "R8 irq one cycle", irq, 0);
    ea = (r == 0) ? 1 : per(r) / 2;
    check(pulses == 8, "R3 pulse count", pulses, 8);
    check(amin == ea && amax == ea, "R5 active width", amax, ea);
    check(rx_data == sv, "R3 received byte", rx_data, sv);
    check(s_rx == tx, "R7 slave captured byte", s_rx, tx);
    mon = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_all;
    logic [7:0] tx, sv, cfgb, prev_rx;
    int ic;
    // R1 reset state
    check(ctl_rdata == 8'h00, "R1 control reset", ctl_rdata, 0);
    check(sck == 1'b0 && mosi == 1'b0, "R1 pins reset", {sck, mosi}, 0);
    check(irq == 1'b0 && tx_ready == 1'b0, "R1 irq/ready reset", {irq, tx_ready}, 0);
    check(rx_data == 8'h00, "R1 rx reset", rx_data, 0);

    // Sweep every rate, polarity and phase
    for (int r = 0; r < 4; r++)
      for (int p = 0; p < 2; p++)
        for (int h = 0; h < 2; h++) begin
          b_cpol = p[0]; b_cpha = h[0];
          cfgb = {2'b00, 2'b01, p[0], h[0], 2'(r)};
          write_ctl(cfgb);
          @(negedge clk);
          check(sck == b_cpol, "R6 idle level", sck, b_cpol);
          for (int k = 0; k < 2; k++) begin
            tx = 8'(r * 61 + p * 29 + h * 13 + k * 151 + 7);
            sv = (k == 0) ? (tx ^ 8'hA5) : 8'(tx * 3 + 1);
            run_xfer(tx, sv, r, 1'b0);
          end
        end

    // R8 flag: writing 1 keeps it, writing 0 clears it
    check(ctl_rdata[7] == 1'b1, "R8 flag held after transfer", ctl_rdata[7], 1);
    write_ctl({1'b1, 1'b0, cfgb[5:0]});
    check(ctl_rdata[7] == 1'b1, "R8 write 1 keeps flag", ctl_rdata[7], 1);
    write_ctl({1'b0, 1'b0, cfgb[5:0]});
    check(ctl_rdata[7] == 1'b0, "R8 write 0 clears flag", ctl_rdata[7], 0);

    // R9 byte offered mid-transfer is dropped
    b_cpol = 1'b0; b_cpha = 1'b1;
    write_ctl(8'b0001_0110);
    run_xfer(8'h3C, 8'hC9, 2, 1'b1);
    repeat (4) @(negedge clk);
    check(ctl_rdata[6] == 1'b0, "R9 no second transfer", ctl_rdata[6], 0);

    // R10 abort by leaving master mode
    write_ctl(8'b0001_1011);
    b_cpol = 1'b1; b_cpha = 1'b0;
    prev_rx = rx_data;
    ic = irq_cnt;
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'h5E;
    @(negedge clk); tx_valid = 1'b0;
    repeat (100) @(negedge clk);
    write_ctl(8'b0000_1011);
    check(sck == 1'b1, "R10 sck idle after abort", sck, 1);
    @(negedge clk);
    check(ctl_rdata[6] == 1'b0, "R10 busy cleared", ctl_rdata[6], 0);
    repeat (900) @(negedge clk);
    check(irq_cnt == ic, "R10 no irq", irq_cnt - ic, 0);
    check(ctl_rdata[7] == 1'b0, "R10 no flag", ctl_rdata[7], 0);
    check(rx_data == prev_rx, "R10 rx kept", rx_data, prev_rx);

    // R2 slave and reserved codes accept nothing
    for (int m = 2; m < 4; m++) begin
      write_ctl({2'b00, 2'(m), 4'b0100});
      ic = irq_cnt;
      check(tx_ready == 1'b0, "R2 ready low off-master", tx_ready, 0);
      @(negedge clk); tx_valid = 1'b1; tx_data = 8'h99;
      @(negedge clk); tx_valid = 1'b0;
      repeat (60) @(negedge clk);
      check(irq_cnt == ic && ctl_rdata[6] == 1'b0, "R2 no transfer off-master", irq_cnt - ic, 0);
      check(sck == 1'b0, "R2 sck idle off-master", sck, 0);
    end
  endtask

  initial begin
    bit timeout = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      run_all();
      begin repeat (150000) @(posedge clk); timeout = 1; end
    join_any
    disable fork;
    if (timeout) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule